// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Sleep Wake-Up

This block is a 16-bit down-counting timer for a processor peripheral bus. A single data address serves two purposes. A read returns the live count, and a write sets the reload value. The same write also restarts the count from that value at once. When the counter is at zero and a count event arrives, this is an underflow. On underflow the counter takes the reload value instead of wrapping. It may then raise a one-cycle interrupt pulse, toggle a timer output pin, and, in one clock mode, pulse a wake request to a sleeping processor.

Count events come from one of three sources, selected by a two-bit field:
- the system clock divided by two,
- rising edges of an external user input,
- rising edges of a slow 32 kHz clock.

All logic runs on the system clock. The two asynchronous sources pass through a two-flop synchronizer and an edge detector. One slow-clock encoding also enables wake-up.

The counter control is a two-state machine: `ST_HALT` (count frozen) and `ST_COUNT` (count events decrement). The transition HALT→COUNT is taken on the clock after the run bit reads set. The transition COUNT→HALT is taken on the clock after the run bit reads clear. The state therefore follows the run bit with one cycle of lag.

Top module: `dntmr_top`

## Requirements
- R1: After reset the count, the reload value and every control field are 0, so the source is system clock ÷ 2 and the state is `ST_HALT`. `irq_o`, `wake_o` and `tmr_out` are all low.
- R2: A read with `bus_addr`=0 returns the live count. With `bus_addr`=1 it returns the control register, laid out as bit0 run, bit1 interrupt enable, bit2 output enable, bits5:4 source; all other bits read 0.
- R3: A write with `bus_addr`=0 stores the data as the reload value and loads it into the counter at the same clock edge. This retrigger takes priority over a count event on that edge.
- R4: In `ST_COUNT`, each count event lowers the count by one. In `ST_HALT` the count holds. The state follows the run bit one clock late.
- R5: A count event while the count is 0 is an underflow. The counter then takes the most recently written reload value and never reads 0xFFFF because of it.
- R6: Source 00 gives one count event every two system clocks. Source 01 gives one event per rising edge of `user_in`. Sources 10 and 11 give one event per rising edge of `slow_clk_in`. A synchronized edge reaches the counter three clocks after the input changes.
- R7: When the interrupt enable is set, `irq_o` pulses high for one clock in the cycle after each underflow. It stays low otherwise.
- R8: `tmr_out` toggles on every underflow and is forced low while the output enable is clear.
- R9: With source 11, an underflow while `sleep_in` is high pulses `wake_o` for one clock in the following cycle, regardless of the interrupt enable. `wake_o` never pulses with any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = count/reload, 1 = control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| user_in | input | 1 | Asynchronous external count input |
| slow_clk_in | input | 1 | Asynchronous 32 kHz clock |
| sleep_in | input | 1 | Processor is asleep |
| irq_o | output | 1 | Underflow interrupt pulse |
| wake_o | output | 1 | Wake-up pulse |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bound checker evaluates several properties on every clock:
- the counter loads on a data write;
- the count is frozen in `ST_HALT`;
- underflow never wraps;
- `irq_o` and `wake_o` are single-cycle pulses, each gated by its enable and mode;
- `tmr_out` is low whenever its enable is clear.

Only the bench's scenarios can show the decrement rate of each source and the three-clock synchronizer delay. The same holds for the retrigger of a running count and for wake pulses appearing or not as `sleep_in` and the mode change. The bench's scenarios establish these by comparing every cycle against a behavioural model.

// File: rtl/dntmr_pkg.sv
package dntmr_pkg;

    typedef enum logic [1:0] {
        SRC_SYS_HALF  = 2'b00,
        SRC_USER      = 2'b01,
        SRC_SLOW      = 2'b10,
        SRC_SLOW_WAKE = 2'b11
    } src_sel_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_e;

    typedef struct packed {
        src_sel_e src;
        logic     out_en;
        logic     irq_en;
        logic     run;
    } ctl_t;

    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_IRQ_BIT  = 1;
    localparam int CTL_OUT_BIT  = 2;
    localparam int CTL_SRC_LSB  = 4;
    localparam int CTL_USED_W   = 6;

endpackage

// File: rtl/dntmr_sync_edge.sv
module dntmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dntmr_tick.sv
module dntmr_tick
    import dntmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e src,
    input  logic     user_in,
    input  logic     slow_in,
    output logic     tick_o
);
    logic half_q;
    logic user_rise;
    logic slow_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    dntmr_sync_edge #(.STAGES(SYNC_STAGES)) u_user_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (user_in),
        .rise_o   (user_rise)
    );

    dntmr_sync_edge #(.STAGES(SYNC_STAGES)) u_slow_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_in),
        .rise_o   (slow_rise)
    );

    always_comb begin
        unique case (src)
            SRC_SYS_HALF:  tick_o = half_q;
            SRC_USER:      tick_o = user_rise;
            SRC_SLOW,
            SRC_SLOW_WAKE: tick_o = slow_rise;
        endcase
    end
endmodule

// File: rtl/dntmr_regs.sv
module dntmr_regs
    import dntmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] bus_rdata,
    output ctl_t         ctl_o,
    output logic         ld_req_o
);
    localparam int PAD_W = W - CTL_USED_W;

    ctl_t ctl_q;
    logic ctl_wr;
    logic wdata_unused;

    assign ctl_wr       = bus_sel & bus_wr & bus_addr;
    assign ld_req_o     = bus_sel & bus_wr & ~bus_addr;
    assign wdata_unused = ^{bus_wdata[W-1:CTL_USED_W], bus_wdata[3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.src    <= SRC_SYS_HALF;
            ctl_q.out_en <= 1'b0;
            ctl_q.irq_en <= 1'b0;
            ctl_q.run    <= 1'b0;
        end else if (ctl_wr) begin
            ctl_q.src    <= src_sel_e'(bus_wdata[CTL_SRC_LSB +: 2]);
            ctl_q.out_en <= bus_wdata[CTL_OUT_BIT];
            ctl_q.irq_en <= bus_wdata[CTL_IRQ_BIT];
            ctl_q.run    <= bus_wdata[CTL_RUN_BIT];
        end
    end

    always_comb begin
        if (bus_addr)
            bus_rdata = {{PAD_W{1'b0}}, ctl_q.src, 1'b0,
                         ctl_q.out_en, ctl_q.irq_en, ctl_q.run};
        else
            bus_rdata = count_i;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/dntmr_core.sv
module dntmr_core
    import dntmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         irq_en,
    input  logic         out_en,
    input  logic         wake_mode,
    input  logic         tick,
    input  logic         ld_req,
    input  logic [W-1:0] ld_val,
    input  logic         sleep_in,
    output logic [W-1:0] count_o,
    output logic         irq_o,
    output logic         wake_o,
    output logic         tmr_out
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    cnt_state_e state_q, state_d;
    logic [W-1:0] count_q, reload_q;
    logic         tog_q, irq_q, wake_q;
    logic         step, underflow;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run)  state_d = ST_COUNT;
            ST_COUNT: if (!run) state_d = ST_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        step      = 1'b0;
        underflow = 1'b0;
        unique case (state_q)
            ST_HALT: ;
            ST_COUNT: begin
                step      = tick & ~ld_req;
                underflow = tick & ~ld_req & (count_q == '0);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            tog_q    <= 1'b0;
            irq_q    <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            if (ld_req) begin
                reload_q <= ld_val;
                count_q  <= ld_val;
            end else if (underflow) begin
                count_q  <= reload_q;
            end else if (step) begin
                count_q  <= count_q - ONE;
            end
            tog_q  <= tog_q ^ underflow;
            irq_q  <= underflow & irq_en;
            wake_q <= underflow & wake_mode & sleep_in;
        end
    end

    assign count_o = count_q;
    assign irq_o   = irq_q;
    assign wake_o  = wake_q;
    assign tmr_out = tog_q & out_en;
endmodule

// File: rtl/dntmr_top.sv
module dntmr_top
    import dntmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         user_in,
    input  logic         slow_clk_in,
    input  logic         sleep_in,
    output logic         irq_o,
    output logic         wake_o,
    output logic         tmr_out
);
    ctl_t         ctl;
    logic         ld_req;
    logic         tick;
    logic [W-1:0] count;

    dntmr_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count_i   (count),
        .bus_rdata (bus_rdata),
        .ctl_o     (ctl),
        .ld_req_o  (ld_req)
    );

    dntmr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ctl.src),
        .user_in (user_in),
        .slow_in (slow_clk_in),
        .tick_o  (tick)
    );

    dntmr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl.run),
        .irq_en    (ctl.irq_en),
        .out_en    (ctl.out_en),
        .wake_mode (ctl.src == SRC_SLOW_WAKE),
        .tick      (tick),
        .ld_req    (ld_req),
        .ld_val    (bus_wdata),
        .sleep_in  (sleep_in),
        .count_o   (count),
        .irq_o     (irq_o),
        .wake_o    (wake_o),
        .tmr_out   (tmr_out)
    );
endmodule

// File: rtl/dntmr_chk.sv
module dntmr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_req,
    input logic [W-1:0] ld_val,
    input logic [W-1:0] count,
    input logic [W-1:0] reload,
    input logic         counting,
    input logic         irq_en,
    input logic         out_en,
    input logic [1:0]   src,
    input logic         sleep_in,
    input logic         irq_o,
    input logic         wake_o,
    input logic         tmr_out
);
    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> (count == $past(ld_val) && reload == $past(ld_val))); // R3

    AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !ld_req) |=> $stable(count)); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !ld_req) |=> (count == '0 || count == $past(reload))); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(irq_en)); // R7

    AST_OUT_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !tmr_out); // R8

    AST_WAKE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(src) == 2'b11 && $past(sleep_in))); // R9

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o); // R9
endmodule

bind dntmr_top dntmr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_req   (ld_req),
    .ld_val   (bus_wdata),
    .count    (u_core.count_q),
    .reload   (u_core.reload_q),
    .counting (u_core.state_q == dntmr_pkg::ST_COUNT),
    .irq_en   (ctl.irq_en),
    .out_en   (ctl.out_en),
    .src      (ctl.src),
    .sleep_in (sleep_in),
    .irq_o    (irq_o),
    .wake_o   (wake_o),
    .tmr_out  (tmr_out)
);

// File: tb/dntmr_top_bench.sv
`timescale 1ns/1ps
module dntmr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        user_in = 1'b0, slow_clk_in = 1'b0, sleep_in = 1'b0;
    logic        irq_o, wake_o, tmr_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dntmr_top u_dntmr_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .user_in(user_in), .slow_clk_in(slow_clk_in), .sleep_in(sleep_in),
        .irq_o(irq_o), .wake_o(wake_o), .tmr_out(tmr_out)
    );

    // behavioural reference
    logic [15:0] m_cnt, m_rel;
    logic [5:0]  m_ctl;
    logic        m_st, m_half, m_tog, m_irq, m_wake;
    logic [2:0]  m_u, m_s;

    always @(posedge clk or negedge rst_n) begin
        logic tk, wr0, wr1, uf;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_ctl = 0; m_st = 0; m_half = 0;
            m_tog = 0; m_irq = 0; m_wake = 0; m_u = 0; m_s = 0;
        end else begin
            case (m_ctl[5:4])
                2'b00:   tk = m_half;
                2'b01:   tk = m_u[1] & ~m_u[2];
                default: tk = m_s[1] & ~m_s[2];
            endcase
            wr0 = bus_sel & bus_wr & ~bus_addr;
            wr1 = bus_sel & bus_wr & bus_addr;
            uf  = m_st & tk & ~wr0 & (m_cnt == 0);
            if (wr0) begin m_cnt = bus_wdata; m_rel = bus_wdata; end
            else if (m_st && tk) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 16'd1;
            m_irq  = uf & m_ctl[1];
            m_wake = uf & (m_ctl[5:4] == 2'b11) & sleep_in;
            m_tog  = m_tog ^ uf;
            m_st   = m_ctl[0];
            if (wr1) m_ctl = bus_wdata[5:0] & 6'h37;
            m_half = ~m_half;
            m_u = {m_u[1:0], user_in};
            m_s = {m_s[1:0], slow_clk_in};
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 R5 R6 count/read", bus_rdata, bus_addr ? {10'b0, m_ctl} : m_cnt);
            chk("R7 irq", {15'b0, irq_o}, {15'b0, m_irq});
            chk("R9 wake", {15'b0, wake_o}, {15'b0, m_wake});
            chk("R8 tmr_out", {15'b0, tmr_out}, {15'b0, m_tog & m_ctl[2]});
        end
    end

    task automatic tick_wait(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick_wait(1);
        bus_sel = 0; bus_wr = 0; bus_addr = 0;
    endtask

    task automatic pulse_user(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            user_in = 1; tick_wait(half);
            user_in = 0; tick_wait(half);
        end
    endtask

    task automatic pulse_slow(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            slow_clk_in = 1; tick_wait(half);
            slow_clk_in = 0; tick_wait(half);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] c0;
        tick_wait(3);
        rst_n = 1;
        tick_wait(1);
        // R1: reset state
        chk("R1 count", bus_rdata, 16'h0000);
        bus_addr = 1; tick_wait(1);
        chk("R1 control", bus_rdata, 16'h0000);
        chk("R1 outputs", {13'b0, irq_o, wake_o, tmr_out}, 16'h0000);
        bus_addr = 0;

        // R2: control readback masks unused bits
        bus_write(1, 16'hFFFF);
        bus_addr = 1; tick_wait(1);
        chk("R2 control readback", bus_rdata, 16'h0037);
        bus_addr = 0;
        bus_write(1, 16'h0000);

        // R3: write loads counter at once
        bus_write(0, 16'd100);
        chk("R3 load", bus_rdata, 16'd100);
        bus_write(1, 16'h0007);
        tick_wait(3);
        c0 = bus_rdata;
        tick_wait(10);
        chk("R6 half-rate decrement", c0 - bus_rdata, 16'd5);

        // R4: halt holds count
        bus_write(1, 16'h0006);
        tick_wait(2);
        c0 = bus_rdata;
        tick_wait(12);
        chk("R4 hold", bus_rdata, c0);

        // R5: short reload, repeated underflows
        bus_write(0, 16'd3);
        bus_write(1, 16'h0007);
        tick_wait(40);
        bus_write(0, 16'd0);
        tick_wait(20);

        // R3: retrigger while running
        bus_write(0, 16'd50);
        tick_wait(20);
        bus_write(0, 16'd40);
        chk("R3 retrigger", bus_rdata, 16'd40);
        tick_wait(5);

        // R6: user input source
        bus_write(0, 16'd2);
        bus_write(1, 16'h0017);
        pulse_user(12, 3);
        pulse_user(6, 1);

        // R9: slow clock without wake mode
        sleep_in = 1;
        bus_write(1, 16'h0027);
        pulse_slow(10, 4);

        // R9: wake mode, irq disabled
        bus_write(1, 16'h0035);
        pulse_slow(10, 4);
        sleep_in = 0;
        pulse_slow(6, 4);
        sleep_in = 1;
        bus_write(1, 16'h0037);
        pulse_slow(6, 3);

        // R8: output enable clear
        bus_write(1, 16'h0003);
        bus_write(0, 16'd1);
        tick_wait(30);
        chk("R8 tmr_out low", {15'b0, tmr_out}, 16'h0000);

        tick_wait(2);
        done = 1;
        summary();
        $finish;
    end
endmodule